// File: doc/BRIEF.md
# Lockable Security Control Register

This block is a small slice of a register bank. It holds three registers that share one 32-bit word bus. The first is a security and debug control word. The second is a lock word whose bits can only be set. The third is a write-only key register. Each lock bit freezes one fixed group of control fields, so software can settle the security settings early and then make them permanent until the next reset.

A key write is the only path that reaches the control word past its locks. The correct key sets the reconfiguration-grant bit and the 3-bit decryption-enable field, and it opens the register space. Any other key value clears both and closes the space. While the space is closed, reads return zero and writes are dropped. The key register stays writable, so a correct key can open the space again. The control word and the lock word are always present on output pins. A one-cycle error pulse reports a decryption-enable field that holds a mixed value.

The bus carries no back-pressure. Every strobe with `bus_sel` high is accepted in its own cycle. Read data returns with `bus_rvalid` exactly one cycle later, and no stall is possible.

Top module: `seclock_ctrl`

## Requirements
- R1: After reset the control word is 0x0C006000 (bits 27, 26, 14 and 13 set), the lock word is 0, `space_open` is 1 and `cfg_err` is 0.
- R2: Byte addresses select the registers: control at 0x00, lock at 0x04 and key at 0x08. A read strobe produces `bus_rvalid` high with the data in the next cycle. A write strobe produces no `bus_rvalid`. An access with address bits 1:0 not equal to 00, or to an unmapped address, reads zero and changes nothing.
- R3: In the control word only bits 27, 26, 24 and 15:0 can be written. Writes to bit 31 and to every other bit are ignored, and those bits read as zero.
- R4: A lock write ORs data bits 4:0 into the lock word, and upper data bits are dropped. No write can clear a lock bit; only reset clears it.
- R5: The lock groups are as follows. Lock bit 0 guards control bits 6:0. Lock bit 1 guards bit 7. Lock bit 2 guards bit 8. Lock bit 3 guards field 11:9. Lock bit 4 guards bit 12.
- R6: On a control write, every group whose lock bit is set keeps its old value. Every unlocked writable bit takes the written value.
- R7: Writing 0x757BDF0D to the key register sets control bit 27 and sets field 11:9 to 111, whatever the locks are. It also sets `space_open`.
- R8: Writing any other value to the key register clears control bit 27 and field 11:9, whatever the locks are. It also clears `space_open`.
- R9: While `space_open` is 0, reads of any address return zero and writes to the control and lock registers are ignored. Key writes still take effect.
- R10: `cfg_err` is high for one cycle, in the cycle after a control write whose stored field 11:9 is neither 000 nor 111. Otherwise it is low.
- R11: A read of the key register returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| ctrl_word | output | 32 | Current control word |
| lock_word | output | 5 | Current lock word |
| space_open | output | 1 | Register space accessible |
| cfg_err | output | 1 | Inconsistent decryption-enable field written |

## Verification
A write takes effect at the clock edge that samples its strobe. So `ctrl_word`, `lock_word` and `space_open` are due one cycle after the strobe. `cfg_err` and read data with `bus_rvalid` are due in that same following cycle, and `cfg_err` is low again the cycle after. Each bus task drives its strobe on a falling edge and samples every output on the next falling edge. A second idle sample confirms that the error pulse lasts only one cycle. The bench sweeps all 32 lock values, and for each one it compares the control word read back against an arithmetic model. It also checks the field-error flag for all eight values of the 3-bit field.

// File: rtl/seclock_pkg.sv
package seclock_pkg;

  localparam int DATA_W    = 32;
  localparam int NUM_LOCKS = 5;

  // writable control bits: 27, 26, 24, 15:0
  localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h0D00_FFFF;
  localparam logic [DATA_W-1:0] CTRL_RST   = 32'h0C00_6000;
  localparam logic [DATA_W-1:0] GRANT_BIT  = 32'h0800_0000;
  localparam logic [DATA_W-1:0] DECR_FIELD = 32'h0000_0E00;

  typedef enum logic [1:0] {
    RS_ZERO = 2'd0,
    RS_CTRL = 2'd1,
    RS_LOCK = 2'd2
  } rsel_e;

  // control bits guarded by one lock bit
  function automatic logic [DATA_W-1:0] group_mask(input int idx);
    logic [DATA_W-1:0] m;
    case (idx)
      0:       m = 32'h0000_007F;
      1:       m = 32'h0000_0080;
      2:       m = 32'h0000_0100;
      3:       m = DECR_FIELD;
      4:       m = 32'h0000_1000;
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/seclock_decode.sv
module seclock_decode
  import seclock_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 'h00,
  parameter logic [ADDR_W-1:0] LOCK_OFF = 'h04,
  parameter logic [ADDR_W-1:0] KEY_OFF  = 'h08
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              open,
  output logic              wr_ctrl,
  output logic              wr_lock,
  output logic              wr_key,
  output rsel_e             rd_src
);

  logic aligned;
  logic wr_ok;
  logic rd_ok;

  always_comb begin
    aligned = (addr[1:0] == 2'b00);
    wr_ok   = sel && wr && aligned;
    rd_ok   = sel && !wr && aligned && open;
    wr_ctrl = wr_ok && open && (addr == CTRL_OFF);
    wr_lock = wr_ok && open && (addr == LOCK_OFF);
    wr_key  = wr_ok && (addr == KEY_OFF);
    rd_src  = RS_ZERO;
    if (rd_ok) begin
      if (addr == CTRL_OFF)      rd_src = RS_CTRL;
      else if (addr == LOCK_OFF) rd_src = RS_LOCK;
      else                       rd_src = RS_ZERO;
    end
  end

endmodule

// File: rtl/seclock_lockreg.sv
module seclock_lockreg
  import seclock_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [NUM_LOCKS-1:0] wdata,
  output logic [NUM_LOCKS-1:0] lock_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lock_q <= '0;
    else if (wr_en) lock_q <= lock_q | wdata;
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q != '0) |=> ((lock_q & $past(lock_q)) == $past(lock_q))); // R4

endmodule

// File: rtl/seclock_keygate.sv
module seclock_keygate
  import seclock_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY = 32'h757B_DF0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_key,
  input  logic [DATA_W-1:0] wdata,
  output logic              key_hit,
  output logic              key_miss,
  output logic              open_q
);

  always_comb begin
    key_hit  = wr_key && (wdata == KEY);
    key_miss = wr_key && (wdata != KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        open_q <= 1'b1;
    else if (key_hit)  open_q <= 1'b1;
    else if (key_miss) open_q <= 1'b0;
  end

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_key && wdata == KEY) |=> open_q); // R7
  AST_BAD_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_key && wdata != KEY) |=> !open_q); // R8

endmodule

// File: rtl/seclock_ctrlreg.sv
module seclock_ctrlreg
  import seclock_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_LOCKS-1:0] lock,
  input  logic                 key_set,
  input  logic                 key_clr,
  output logic [DATA_W-1:0]    ctrl_q,
  output logic                 err_q
);

  logic [DATA_W-1:0] held_mask;
  logic [DATA_W-1:0] wr_val;
  logic [DATA_W-1:0] nxt;
  logic              mixed;

  always_comb begin
    held_mask = '0;
    for (int g = 0; g < NUM_LOCKS; g++) begin
      if (lock[g]) held_mask = held_mask | group_mask(g);
    end
    wr_val = ((wdata & ~held_mask) | (ctrl_q & held_mask)) & CTRL_WMASK;
    nxt = ctrl_q;
    if (key_set)      nxt = ctrl_q | GRANT_BIT | DECR_FIELD;
    else if (key_clr) nxt = ctrl_q & ~(GRANT_BIT | DECR_FIELD);
    else if (wr_en)   nxt = wr_val;
    mixed = (wr_val[11:9] != 3'b000) && (wr_val[11:9] != 3'b111);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      err_q  <= 1'b0;
    end else begin
      ctrl_q <= nxt;
      err_q  <= wr_en && !key_set && !key_clr && mixed;
    end
  end

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_hold
    localparam logic [DATA_W-1:0] GM = group_mask(g);
    AST_LOCKED_GROUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (lock[g] && !key_set && !key_clr) |=> ((ctrl_q & GM) == $past(ctrl_q & GM))); // R6
  end

  AST_KEY_SETS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    key_set |=> (ctrl_q[27] && ctrl_q[11:9] == 3'b111)); // R7
  AST_KEY_CLEARS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    key_clr |=> (!ctrl_q[27] && ctrl_q[11:9] == 3'b000)); // R8
  AST_ERR_MEANS_MIXED: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (ctrl_q[11:9] != 3'b000 && ctrl_q[11:9] != 3'b111)); // R10
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !key_set && !key_clr) |=> ((ctrl_q & ~CTRL_WMASK) == '0)); // R3

endmodule

// File: rtl/seclock_ctrl.sv
module seclock_ctrl
  import seclock_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 'h00,
  parameter logic [ADDR_W-1:0] LOCK_OFF = 'h04,
  parameter logic [ADDR_W-1:0] KEY_OFF  = 'h08,
  parameter logic [31:0] KEY = 32'h757B_DF0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic [31:0]       ctrl_word,
  output logic [4:0]        lock_word,
  output logic              space_open,
  output logic              cfg_err
);

  logic  wr_ctrl;
  logic  wr_lock;
  logic  wr_key;
  logic  key_hit;
  logic  key_miss;
  rsel_e rd_src;
  logic [DATA_W-1:0] rd_mux;

  seclock_decode #(
    .ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF), .LOCK_OFF(LOCK_OFF), .KEY_OFF(KEY_OFF)
  ) u_decode (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .open(space_open),
    .wr_ctrl(wr_ctrl), .wr_lock(wr_lock), .wr_key(wr_key), .rd_src(rd_src)
  );

  seclock_keygate #(.KEY(KEY)) u_key (
    .clk(clk), .rst_n(rst_n), .wr_key(wr_key), .wdata(bus_wdata),
    .key_hit(key_hit), .key_miss(key_miss), .open_q(space_open)
  );

  seclock_lockreg u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_lock),
    .wdata(bus_wdata[NUM_LOCKS-1:0]), .lock_q(lock_word)
  );

  seclock_ctrlreg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(bus_wdata),
    .lock(lock_word), .key_set(key_hit), .key_clr(key_miss),
    .ctrl_q(ctrl_word), .err_q(cfg_err)
  );

  always_comb begin
    case (rd_src)
      RS_CTRL: rd_mux = ctrl_word;
      RS_LOCK: rd_mux = {{(DATA_W-NUM_LOCKS){1'b0}}, lock_word};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_sel && !bus_wr;
      bus_rdata  <= rd_mux;
    end
  end

  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid); // R2
  AST_CLOSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !space_open) |=> (bus_rdata == '0)); // R9
  AST_CLOSED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !space_open && bus_addr != KEY_OFF)
      |=> ($stable(ctrl_word) && $stable(lock_word))); // R9

endmodule

// File: tb/seclock_ctrl_test.sv
module seclock_ctrl_test;

  localparam logic [31:0] KEYV  = 32'h757B_DF0D;
  localparam logic [31:0] WMASK = 32'h0D00_FFFF;
  localparam logic [31:0] RSTV  = 32'h0C00_6000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] ctrl_word;
  logic [4:0]  lock_word;
  logic        space_open;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  seclock_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ctrl_word(ctrl_word), .lock_word(lock_word),
    .space_open(space_open), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, input string req);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    check(req, {31'd0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] held(input logic [4:0] lk);
    logic [31:0] m = '0;
    if (lk[0]) m |= 32'h7F;
    if (lk[1]) m |= 32'h80;
    if (lk[2]) m |= 32'h100;
    if (lk[3]) m |= 32'hE00;
    if (lk[4]) m |= 32'h1000;
    return m;
  endfunction

  function automatic logic [31:0] model_wr(input logic [31:0] cur, input logic [31:0] wd,
                                           input logic [4:0] lk);
    return ((wd & ~held(lk)) | (cur & held(lk))) & WMASK;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] exp_c;
    do_reset();
    // R1 reset state
    check("R1 ctrl", ctrl_word, RSTV);
    check("R1 lock", {27'd0, lock_word}, 32'd0);
    check("R1 open", {31'd0, space_open}, 32'd1);
    check("R1 err", {31'd0, cfg_err}, 32'd0);

    // R3 writable bits and reserved bits
    bus_write(8'h00, 32'hFFFF_FFFF);
    check("R2 no rvalid on write", {31'd0, bus_rvalid}, 32'd0);
    bus_read(8'h00, rd, "R2 rvalid");
    check("R3 all ones", rd, WMASK);
    bus_write(8'h00, 32'h0);
    bus_read(8'h00, rd, "R2 rvalid");
    check("R3 all zeros", rd, 32'h0);

    // R4 R5 R6 lock sweep over all 32 lock values
    for (int l = 0; l < 32; l++) begin
      do_reset();
      bus_write(8'h00, 32'hA5A5_5A5A);
      exp_c = model_wr(RSTV, 32'hA5A5_5A5A, 5'd0);
      bus_write(8'h04, {27'h7FF_FFFF, 5'(l)});
      bus_write(8'h00, 32'h5A5A_A5A5);
      exp_c = model_wr(exp_c, 32'h5A5A_A5A5, 5'(l));
      bus_read(8'h00, rd, "R2 rvalid");
      check("R5 R6 lock sweep read", rd, exp_c);
      check("R6 ctrl port", ctrl_word, exp_c);
      bus_write(8'h04, 32'h0);
      bus_read(8'h04, rd, "R2 rvalid");
      check("R4 sticky lock", rd, 32'(l));
    end

    // R10 field consistency sweep
    do_reset();
    for (int v = 0; v < 8; v++) begin
      bus_write(8'h00, 32'(v) << 9);
      check("R10 err pulse", {31'd0, cfg_err},
            {31'd0, (v != 0 && v != 7)});
      @(negedge clk);
      check("R10 err one cycle", {31'd0, cfg_err}, 32'd0);
    end

    // R7 correct key overrides locks
    do_reset();
    bus_write(8'h00, 32'h0000_0000);
    bus_write(8'h04, 32'h1F);
    bus_write(8'h08, KEYV);
    check("R7 grant and field", ctrl_word & 32'h0800_0E00, 32'h0800_0E00);
    check("R7 open", {31'd0, space_open}, 32'd1);
    bus_read(8'h08, rd, "R2 rvalid");
    check("R11 key reads zero", rd, 32'h0);

    // R8 wrong key clears and closes
    bus_write(8'h08, KEYV ^ 32'h1);
    check("R8 cleared", ctrl_word & 32'h0800_0E00, 32'h0);
    check("R8 closed", {31'd0, space_open}, 32'd0);

    // R9 closed space
    do_reset();
    bus_write(8'h08, 32'h1234_5678);
    exp_c = RSTV & ~32'h0800_0E00;
    bus_read(8'h00, rd, "R2 rvalid");
    check("R9 closed read", rd, 32'h0);
    bus_write(8'h00, 32'h0000_00FF);
    check("R9 ctrl write ignored", ctrl_word, exp_c);
    bus_write(8'h04, 32'h1F);
    check("R9 lock write ignored", {27'd0, lock_word}, 32'd0);
    bus_write(8'h08, KEYV);
    check("R9 key reopens", {31'd0, space_open}, 32'd1);
    bus_read(8'h00, rd, "R2 rvalid");
    check("R9 reopened read", rd, exp_c | 32'h0800_0E00);

    // R2 misaligned and unmapped
    do_reset();
    bus_write(8'h01, 32'h0000_00FF);
    check("R2 misaligned write", ctrl_word, RSTV);
    bus_read(8'h02, rd, "R2 rvalid");
    check("R2 misaligned read", rd, 32'h0);
    bus_read(8'h10, rd, "R2 rvalid");
    check("R2 unmapped read", rd, 32'h0);
    bus_write(8'h09, KEYV ^ 32'h1);
    check("R2 misaligned key", {31'd0, space_open}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule